// File: doc/BRIEF.md
# Dual-Pixel Per-Channel Convergence Delay

This block realigns the red, green and blue planes of a video line that arrives two pixels per clock. Lane "even" carries pixels 0, 2, 4 and so on; lane "odd" carries pixels 1, 3, 5 and so on. Each colour channel has its own pixel delay. Shifting one plane to the right by a few pixels cancels a measured misregistration between the three panels, so the displayed image moves opposite to the error.

A delay of an even number of pixels is a plain lane-parallel delay of half that many clocks. An odd delay moves every pixel into the opposite lane. The output even lane then takes an odd pixel from one clock earlier, and the output odd lane takes an even pixel from the same clock. Inputs sampled while data-enable is low are treated as black, so pixels shifted into the start of a line are zero. Programmed delays are picked up only on the rising edge of horizontal sync, which keeps one line from mixing two settings.

Top module: `pixel_align`

## Requirements
- R1: For channel delay d, output pixel n equals effective input pixel n−d. Input pixel 2t is the even lane at input clock t and pixel 2t+1 is the odd lane. With an even d, both lanes keep their lane, delayed by d/2 clocks.
- R2: With an odd d, the output even lane carries an odd-lane input pixel and the output odd lane carries an even-lane input pixel. With d=1, the output even lane is the previous clock's odd pixel and the output odd lane is the current clock's even pixel.
- R3: The three channels use their own delays independently. The delay of one channel has no effect on the other two.
- R4: Each delay is a 4-bit unsigned value in cfgR, cfgG and cfgB, covering 0 to 15 pixels. The value 15 is handled like any other.
- R5: Input pixels sampled while deIn is low count as zero. Any output pixel whose source falls in blanking is 0, whatever data was driven there.
- R6: hsyncOut, deOut and all data outputs follow their inputs by exactly one clock.
- R7: cfgR, cfgG and cfgB are captured only in the clock where hsyncIn is high and was low in the previous clock. The captured values first apply to input pixels of the following clock. Changes at any other time have no effect.
- R8: After synchronous active-high reset, all outputs are zero and all three delays are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgR | input | 4 | Red delay in pixels |
| cfgG | input | 4 | Green delay in pixels |
| cfgB | input | 4 | Blue delay in pixels |
| hsyncIn | input | 1 | Horizontal sync, active high |
| deIn | input | 1 | Data enable |
| inEvenR | input | 10 | Red, even pixel |
| inEvenG | input | 10 | Green, even pixel |
| inEvenB | input | 10 | Blue, even pixel |
| inOddR | input | 10 | Red, odd pixel |
| inOddG | input | 10 | Green, odd pixel |
| inOddB | input | 10 | Blue, odd pixel |
| hsyncOut | output | 1 | Sync delayed by one clock |
| deOut | output | 1 | Enable delayed by one clock |
| outEvenR | output | 10 | Red, even pixel out |
| outEvenG | output | 10 | Green, even pixel out |
| outEvenB | output | 10 | Blue, even pixel out |
| outOddR | output | 10 | Red, odd pixel out |
| outOddG | output | 10 | Green, odd pixel out |
| outOddB | output | 10 | Blue, odd pixel out |

## Verification
Odd delays are the main target. A design that forgets to re-pair the lanes, or that swaps lanes at the wrong clock, shows pixels out of order by one or two positions. The maximum delay of 15 pulls its source from the deepest history stage, so a history one stage too short returns stale or wrong pixels. Non-zero data is driven throughout blanking, so a design that fails to blank leaks garbage into the first pixels of a line. A delay is also rewritten in the middle of a line; a design that loads it outside the sync rising edge shifts the rest of that line.

// File: rtl/pixel_align_pkg.sv
package pixel_align_pkg;
  localparam int NCH   = 3;
  localparam int DLY_W = 4;
  localparam int TAP_W = DLY_W - 1;

  // Control strobes: per channel, whole-pair tap and lane-swap flag
  typedef struct packed {
    logic [NCH-1:0]            swap;
    logic [NCH-1:0][TAP_W-1:0] tap;
  } ctrl_t;
endpackage

// File: rtl/pixel_align_ctrl.sv
module pixel_align_ctrl
  import pixel_align_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hsyncIn,
  input  logic [NCH-1:0][DLY_W-1:0] cfgDelay,
  output ctrl_t                     ctrlBus
);
  logic                      hsyncPrev;
  logic                      loadNow;
  logic [NCH-1:0][DLY_W-1:0] delayReg;

  assign loadNow = hsyncIn & ~hsyncPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsyncPrev <= 1'b0;
      delayReg  <= '0;
    end else begin
      hsyncPrev <= hsyncIn;
      if (loadNow) delayReg <= cfgDelay;
    end
  end

  // Odd pixel delay -> swap lanes; remaining pixels -> whole pairs
  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      ctrlBus.swap[ch] = delayReg[ch][0];
      ctrlBus.tap[ch]  = delayReg[ch][DLY_W-1:1];
    end
  end
endmodule

// File: rtl/pixel_align_path.sv
module pixel_align_path
  import pixel_align_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctrl_t                     ctrlBus,
  input  logic                      hsyncIn,
  input  logic                      deIn,
  input  logic [NCH-1:0][PIX_W-1:0] inEven,
  input  logic [NCH-1:0][PIX_W-1:0] inOdd,
  output logic                      hsyncOut,
  output logic                      deOut,
  output logic [NCH-1:0][PIX_W-1:0] outEven,
  output logic [NCH-1:0][PIX_W-1:0] outOdd
);
  localparam int HIST = 2 ** TAP_W;  // past pairs needed for the largest odd delay

  always_ff @(posedge clk) begin
    if (rst) begin
      hsyncOut <= 1'b0;
      deOut    <= 1'b0;
    end else begin
      hsyncOut <= hsyncIn;
      deOut    <= deIn;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [PIX_W-1:0] curEven, curOdd;
    logic [PIX_W-1:0] histEven [1:HIST];
    logic [PIX_W-1:0] histOdd  [1:HIST];
    logic [PIX_W-1:0] tapEven  [0:HIST];
    logic [PIX_W-1:0] tapOdd   [0:HIST];
    logic [PIX_W-1:0] nextEven, nextOdd;
    logic [PIX_W-1:0] evenQ, oddQ;

    // Blanking pixels enter the history as black
    assign curEven = deIn ? inEven[ch] : '0;
    assign curOdd  = deIn ? inOdd[ch]  : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 1; i <= HIST; i++) begin
          histEven[i] <= '0;
          histOdd[i]  <= '0;
        end
      end else begin
        histEven[1] <= curEven;
        histOdd[1]  <= curOdd;
        for (int i = 2; i <= HIST; i++) begin
          histEven[i] <= histEven[i-1];
          histOdd[i]  <= histOdd[i-1];
        end
      end
    end

    always_comb begin
      tapEven[0] = curEven;
      tapOdd[0]  = curOdd;
      for (int i = 1; i <= HIST; i++) begin
        tapEven[i] = histEven[i];
        tapOdd[i]  = histOdd[i];
      end
    end

    always_comb begin
      if (ctrlBus.swap[ch]) begin
        nextEven = tapOdd[int'(ctrlBus.tap[ch]) + 1];
        nextOdd  = tapEven[ctrlBus.tap[ch]];
      end else begin
        nextEven = tapEven[ctrlBus.tap[ch]];
        nextOdd  = tapOdd[ctrlBus.tap[ch]];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        evenQ <= '0;
        oddQ  <= '0;
      end else begin
        evenQ <= nextEven;
        oddQ  <= nextOdd;
      end
    end

    assign outEven[ch] = evenQ;
    assign outOdd[ch]  = oddQ;
  end
endmodule

// File: rtl/pixel_align.sv
module pixel_align
  import pixel_align_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DLY_W-1:0] cfgR,
  input  logic [DLY_W-1:0] cfgG,
  input  logic [DLY_W-1:0] cfgB,
  input  logic             hsyncIn,
  input  logic             deIn,
  input  logic [PIX_W-1:0] inEvenR,
  input  logic [PIX_W-1:0] inEvenG,
  input  logic [PIX_W-1:0] inEvenB,
  input  logic [PIX_W-1:0] inOddR,
  input  logic [PIX_W-1:0] inOddG,
  input  logic [PIX_W-1:0] inOddB,
  output logic             hsyncOut,
  output logic             deOut,
  output logic [PIX_W-1:0] outEvenR,
  output logic [PIX_W-1:0] outEvenG,
  output logic [PIX_W-1:0] outEvenB,
  output logic [PIX_W-1:0] outOddR,
  output logic [PIX_W-1:0] outOddG,
  output logic [PIX_W-1:0] outOddB
);
  ctrl_t                     ctrlBus;
  logic [NCH-1:0][PIX_W-1:0] evenBus, oddBus, evenRes, oddRes;

  assign evenBus = {inEvenB, inEvenG, inEvenR};
  assign oddBus  = {inOddB, inOddG, inOddR};

  pixel_align_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .hsyncIn  (hsyncIn),
    .cfgDelay ({cfgB, cfgG, cfgR}),
    .ctrlBus  (ctrlBus)
  );

  pixel_align_path #(.PIX_W(PIX_W)) u_path (
    .clk      (clk),
    .rst      (rst),
    .ctrlBus  (ctrlBus),
    .hsyncIn  (hsyncIn),
    .deIn     (deIn),
    .inEven   (evenBus),
    .inOdd    (oddBus),
    .hsyncOut (hsyncOut),
    .deOut    (deOut),
    .outEven  (evenRes),
    .outOdd   (oddRes)
  );

  assign outEvenR = evenRes[0];
  assign outEvenG = evenRes[1];
  assign outEvenB = evenRes[2];
  assign outOddR  = oddRes[0];
  assign outOddG  = oddRes[1];
  assign outOddB  = oddRes[2];
endmodule

// File: rtl/pixel_align_chk.sv
module pixel_align_chk
  import pixel_align_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             hsyncIn,
  input logic             deIn,
  input logic             hsyncOut,
  input logic             deOut,
  input logic [DLY_W-1:0] cfgR,
  input ctrl_t            ctrlBus,
  input logic [PIX_W-1:0] inEvenR,
  input logic [PIX_W-1:0] outEvenR,
  input logic [PIX_W-1:0] outOddR
);
  assert_sync_latency_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hsyncOut == $past(hsyncIn)) && (deOut == $past(deIn)));

  assert_hold_delay_R7: assert property (@(posedge clk) disable iff (rst)
    !$rose(hsyncIn) |=> $stable(ctrlBus));

  assert_load_delay_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(hsyncIn) |=> (ctrlBus.tap[0] == $past(cfgR[DLY_W-1:1])) &&
                       (ctrlBus.swap[0] == $past(cfgR[0])));

  assert_blank_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (!deIn && ctrlBus.tap[0] == '0 && !ctrlBus.swap[0]) |=> (outEvenR == '0));

  assert_pass_through_R1: assert property (@(posedge clk) disable iff (rst)
    (deIn && ctrlBus.tap[0] == '0 && !ctrlBus.swap[0]) |=> (outEvenR == $past(inEvenR)));

  assert_lane_swap_R2: assert property (@(posedge clk) disable iff (rst)
    (deIn && ctrlBus.tap[0] == '0 && ctrlBus.swap[0]) |=> (outOddR == $past(inEvenR)));
endmodule

bind pixel_align pixel_align_chk #(.PIX_W(PIX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .hsyncIn  (hsyncIn),
  .deIn     (deIn),
  .hsyncOut (hsyncOut),
  .deOut    (deOut),
  .cfgR     (cfgR),
  .ctrlBus  (ctrlBus),
  .inEvenR  (inEvenR),
  .outEvenR (outEvenR),
  .outOddR  (outOddR)
);

// File: tb/pixel_align_test.sv
module pixel_align_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst;
  logic [3:0] cfgR, cfgG, cfgB;
  logic       hsyncIn, deIn;
  logic [9:0] inEvenR, inEvenG, inEvenB, inOddR, inOddG, inOddB;
  logic       hsyncOut, deOut;
  logic [9:0] outEvenR, outEvenG, outEvenB, outOddR, outOddG, outOddB;

  pixel_align uut (.*);

  typedef struct {
    logic       hs;
    logic       de;
    logic [9:0] ev [3];
    logic [9:0] od [3];
    string      tag;
  } exp_t;

  exp_t       sb [$];
  int         errors = 0;
  int         checks = 0;
  logic [9:0] effPix [3][0:8191];
  int         cyc = 0;
  int         mdly [3] = '{0, 0, 0};
  logic       mPrevHs = 1'b0;

  function automatic logic [9:0] srcPix(int ch, int n);
    if (n < 0) return 10'd0;
    return effPix[ch][n];
  endfunction

  function automatic logic [9:0] patt(int ch, int n);
    return 10'((n * 37 + ch * 211 + 5) % 1024) | 10'd1;
  endfunction

  task automatic drive(input logic hs, input logic de, input string tag);
    exp_t e;
    logic [9:0] ev [3];
    logic [9:0] od [3];
    @(negedge clk);
    for (int ch = 0; ch < 3; ch++) begin
      ev[ch] = patt(ch, 2 * cyc);
      od[ch] = patt(ch, 2 * cyc + 1);
      effPix[ch][2 * cyc]     = de ? ev[ch] : 10'd0;
      effPix[ch][2 * cyc + 1] = de ? od[ch] : 10'd0;
    end
    hsyncIn = hs; deIn = de;
    inEvenR = ev[0]; inEvenG = ev[1]; inEvenB = ev[2];
    inOddR  = od[0]; inOddG  = od[1]; inOddB  = od[2];
    e.hs = hs; e.de = de; e.tag = tag;
    for (int ch = 0; ch < 3; ch++) begin
      e.ev[ch] = srcPix(ch, 2 * cyc - mdly[ch]);
      e.od[ch] = srcPix(ch, 2 * cyc + 1 - mdly[ch]);
    end
    sb.push_back(e);
    if (hs && !mPrevHs) begin
      mdly[0] = int'(cfgR); mdly[1] = int'(cfgG); mdly[2] = int'(cfgB);
    end
    mPrevHs = hs;
    cyc++;
  endtask

  // Monitor: one comparison per clock, sampled after the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (hsyncOut !== e.hs || deOut !== e.de ||
            outEvenR !== e.ev[0] || outEvenG !== e.ev[1] || outEvenB !== e.ev[2] ||
            outOddR  !== e.od[0] || outOddG  !== e.od[1] || outOddB  !== e.od[2]) begin
          errors++;
          $display("FAIL %s: act hs=%b de=%b E=%0d/%0d/%0d O=%0d/%0d/%0d exp hs=%b de=%b E=%0d/%0d/%0d O=%0d/%0d/%0d",
                   e.tag, hsyncOut, deOut, outEvenR, outEvenG, outEvenB, outOddR, outOddG, outOddB,
                   e.hs, e.de, e.ev[0], e.ev[1], e.ev[2], e.od[0], e.od[1], e.od[2]);
        end
      end
    end
  end

  task automatic line(input int r, input int g, input int b, input string tag,
                      input bit midChange);
    cfgR = 4'(r); cfgG = 4'(g); cfgB = 4'(b);
    repeat (4)  drive(1'b1, 1'b0, tag);
    repeat (10) drive(1'b0, 1'b0, tag);
    for (int i = 0; i < 16; i++) begin
      if (midChange && i == 8) begin
        cfgR = 4'(r ^ 7); cfgG = 4'(g ^ 9); cfgB = 4'(b ^ 5);
      end
      drive(1'b0, 1'b1, tag);
    end
    repeat (6) drive(1'b0, 1'b0, tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; cfgR = 4'd9; cfgG = 4'd3; cfgB = 4'd12;
    hsyncIn = 1'b0; deIn = 1'b1;
    inEvenR = 10'h3ff; inEvenG = 10'h155; inEvenB = 10'h2aa;
    inOddR  = 10'h111; inOddG  = 10'h222; inOddB  = 10'h333;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({hsyncOut, deOut, outEvenR, outEvenG, outEvenB, outOddR, outOddG, outOddB} !== '0) begin
      errors++;
      $display("FAIL R8: act hs=%b de=%b E=%0d/%0d/%0d O=%0d/%0d/%0d exp all zero",
               hsyncOut, deOut, outEvenR, outEvenG, outEvenB, outOddR, outOddG, outOddB);
    end
    rst = 1'b0;
    deIn = 1'b0;
    // R8: delays are 0 after reset until the first sync edge
    repeat (6) drive(1'b0, 1'b1, "R8");
    repeat (4) drive(1'b0, 1'b0, "R8");
    line(0, 0, 0, "R1", 1'b0);
    line(2, 4, 6, "R1", 1'b0);
    line(1, 3, 5, "R2", 1'b0);
    line(7, 0, 12, "R3", 1'b0);
    line(15, 14, 0, "R4", 1'b0);
    line(15, 15, 15, "R5", 1'b0);
    line(5, 8, 2, "R7", 1'b1);
    line(0, 11, 1, "R6", 1'b0);
    repeat (3) drive(1'b0, 1'b0, "R6");
    @(posedge clk);
    #5;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule